// File: doc/BRIEF.md
# Hardware Handler Timer Unit

This block schedules the time-driven and event-driven handlers of a real-time kernel that runs entirely in logic. It keeps three kinds of handler slot: one-shot alarm slots, periodic cyclic slots and interrupt slots. Every timed slot owns its own down-counter. A slot raises its activation request when that counter reaches zero. Interrupt slots watch one input line each, and all of them are tested in the same cycle.

Tasks control the slots through a small command port. Each command carries an opcode, a slot index and a data word. A start command arms a slot. A stop command disarms it. A set-time command loads the reload period of a cyclic slot. A refer command returns the status of a slot. A busy/done handshake brings every command to completion in two cycles.

Activation requests are level signals, one per slot. Each request stays high until the task side acknowledges that slot on its own acknowledge bit.

Top module: `hht_unit`

## Requirements
- R1: After reset every activation request, `cmd_busy_o`, `cmd_done_o` and all read-back outputs are 0, and every slot is inactive with a count of 0.
- R2: An alarm slot started with value V raises its request after the V-th clock edge that follows the command's execute edge (V of 0 or 1 behaves as 1). When it fires it becomes inactive with a count of 0, so a refer command then reports active 0 and count 0.
- R3: A cyclic slot fires on every edge at which its count is 1 or 0. On that edge it reloads the count from its period register, which is written by set-time. With a period of P (P≥1) it fires once every P cycles and stays active.
- R4: An enabled interrupt slot whose input is high at one clock edge shows its request after the next edge, which is at most 2 cycles. While a slot is disabled its input sets nothing.
- R5: All interrupt inputs, and all timer slots, are evaluated in parallel. Slots that fire together raise their request bits in the same cycle.
- R6: A request stays high until its own acknowledge bit is seen at an edge. An acknowledge leaves every other slot untouched. A new firing at the same edge as an acknowledge keeps the request high.
- R7: A command is accepted at an edge where `cmd_valid_i` is high and `cmd_busy_o` is low. `cmd_busy_o` is then high for exactly one cycle. It is followed by a one-cycle `cmd_done_o` pulse, at the edge where the command takes effect, 2 cycles after acceptance.
- R8: Opcode encoding: 0 start, 1 stop, 2 set-time, 3 refer. Slot indices are laid out as alarms first (0..N_ALM-1), then cyclic slots, then interrupt slots. On an interrupt slot, start enables it and stop disables it. Set-time has no effect on alarm or interrupt slots.
- R9: A start command on an active timer slot restarts its count from the new value. Start and stop both override a firing due at the same edge. Stop freezes the count and no later firing occurs.
- R10: Refer returns the slot's count, active/enable bit and request bit as they were just before the execute edge. These values are held until the next refer. A refer to an index of N_H or above returns all zeros. A command to such an index changes no slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Command request |
| cmd_op_i | input | 2 | Opcode (0 start, 1 stop, 2 set-time, 3 refer) |
| cmd_idx_i | input | IDX_W | Slot index |
| cmd_data_i | input | CNT_W | Start value or period |
| cmd_busy_o | output | 1 | Command in progress |
| cmd_done_o | output | 1 | Command completed (one-cycle pulse) |
| rd_count_o | output | CNT_W | Count returned by refer |
| rd_active_o | output | 1 | Active/enable bit returned by refer |
| rd_pend_o | output | 1 | Request bit returned by refer |
| irq_i | input | N_IRQ | Interrupt source lines |
| ack_i | input | N_H | Per-slot acknowledge |
| act_o | output | N_H | Per-slot activation request |

## Verification
The bench attacks the exact firing edge of alarm and cyclic slots. A counter that is off by one, or that fires on reaching zero one edge late, moves the request by a cycle and shows up as a miscompare against the model. It restarts a running slot and stops another one just before expiry: a design that lets the pending firing through would raise a stray request. It raises two interrupt lines together and acknowledges only one of them, which exposes serial scanning, a lost second request or an acknowledge that clears too much. It also drives a disabled interrupt line and refers to an out-of-range index: a design that let either of these leak would set a request or return stale data.

// File: rtl/hht_pkg.sv
package hht_pkg;
   typedef enum logic [1:0] {
      OP_START   = 2'd0,
      OP_STOP    = 2'd1,
      OP_SETTIME = 2'd2,
      OP_REFER   = 2'd3
   } hht_op_e;
endpackage

// File: rtl/hht_cmd_port.sv
module hht_cmd_port
   import hht_pkg::*;
#(
   parameter int IDX_W = 3,
   parameter int CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             valid_i,
   input  logic [1:0]       op_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic [CNT_W-1:0] data_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             exec_o,
   output hht_op_e          op_o,
   output logic [IDX_W-1:0] idx_o,
   output logic [CNT_W-1:0] data_o
);
   logic             busy_q, done_q;
   hht_op_e          op_q;
   logic [IDX_W-1:0] idx_q;
   logic [CNT_W-1:0] data_q;
   logic             take_w;

   assign take_w = valid_i && !busy_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         op_q   <= OP_START;
         idx_q  <= '0;
         data_q <= '0;
      end else begin
         done_q <= busy_q;
         if (busy_q) begin
            busy_q <= 1'b0;
         end else if (take_w) begin
            busy_q <= 1'b1;
            op_q   <= hht_op_e'(op_i);
            idx_q  <= idx_i;
            data_q <= data_i;
         end
      end
   end

   assign busy_o = busy_q;
   assign done_o = done_q;
   assign exec_o = busy_q;
   assign op_o   = op_q;
   assign idx_o  = idx_q;
   assign data_o = data_q;

   // R7
   accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_w |=> busy_q);
   // R7
   busy_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q |=> (!busy_q && done_q));
endmodule

// File: rtl/hht_timer_slot.sv
module hht_timer_slot
   import hht_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter bit CYCLIC = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             sel_i,
   input  hht_op_e          op_i,
   input  logic [CNT_W-1:0] data_i,
   input  logic             ack_i,
   output logic             active_o,
   output logic [CNT_W-1:0] count_o,
   output logic             pend_o
);
   logic             active_q, pend_q;
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] reload_w;
   logic             keep_w;
   logic             override_w, fire_w;

   assign override_w = sel_i && (op_i == OP_START || op_i == OP_STOP);
   assign fire_w     = active_q && (count_q <= CNT_W'(1)) && !override_w;

   generate
      if (CYCLIC) begin : g_cyc
         logic [CNT_W-1:0] period_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni)                              period_q <= '0;
            else if (sel_i && op_i == OP_SETTIME)     period_q <= data_i;
         end
         assign reload_w = period_q;
         assign keep_w   = 1'b1;
         // R3
         reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            fire_w |=> (active_q && count_q == $past(period_q)));
      end else begin : g_alm
         assign reload_w = '0;
         assign keep_w   = 1'b0;
         // R2
         oneshot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            fire_w |=> (!active_q && count_q == '0));
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         active_q <= 1'b0;
         count_q  <= '0;
         pend_q   <= 1'b0;
      end else begin
         if (sel_i && op_i == OP_START) begin
            active_q <= 1'b1;
            count_q  <= data_i;
         end else if (sel_i && op_i == OP_STOP) begin
            active_q <= 1'b0;
         end else if (fire_w) begin
            active_q <= keep_w;
            count_q  <= reload_w;
         end else if (active_q) begin
            count_q  <= count_q - CNT_W'(1);
         end
         if (fire_w)     pend_q <= 1'b1;
         else if (ack_i) pend_q <= 1'b0;
      end
   end

   assign active_o = active_q;
   assign count_o  = count_q;
   assign pend_o   = pend_q;

   // R6
   pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_w |=> pend_q);
   // R6
   ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && !fire_w) |=> !pend_q);
   // R9
   restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i && op_i == OP_START) |=> (active_q && count_q == $past(data_i)));
endmodule

// File: rtl/hht_irq_slot.sv
module hht_irq_slot
   import hht_pkg::*;
(
   input  logic    clk_i,
   input  logic    rst_ni,
   input  logic    sel_i,
   input  hht_op_e op_i,
   input  logic    ack_i,
   input  logic    irq_i,
   output logic    en_o,
   output logic    pend_o
);
   logic irq_q, en_q, pend_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         irq_q  <= 1'b0;
         en_q   <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         irq_q <= irq_i;
         if (sel_i && op_i == OP_START)     en_q <= 1'b1;
         else if (sel_i && op_i == OP_STOP) en_q <= 1'b0;
         if (en_q && irq_q) pend_q <= 1'b1;
         else if (ack_i)    pend_q <= 1'b0;
      end
   end

   assign en_o   = en_q;
   assign pend_o = pend_q;

   // R4
   irq_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_q && irq_q) |=> pend_q);
   // R4
   irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_q && !pend_q) |=> !pend_q);
endmodule

// File: rtl/hht_unit.sv
module hht_unit
   import hht_pkg::*;
#(
   parameter int N_ALM = 2,
   parameter int N_CYC = 2,
   parameter int N_IRQ = 2,
   parameter int CNT_W = 8,
   localparam int N_H   = N_ALM + N_CYC + N_IRQ,
   localparam int IDX_W = (N_H > 1) ? $clog2(N_H) : 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             cmd_valid_i,
   input  logic [1:0]       cmd_op_i,
   input  logic [IDX_W-1:0] cmd_idx_i,
   input  logic [CNT_W-1:0] cmd_data_i,
   output logic             cmd_busy_o,
   output logic             cmd_done_o,
   output logic [CNT_W-1:0] rd_count_o,
   output logic             rd_active_o,
   output logic             rd_pend_o,
   input  logic [N_IRQ-1:0] irq_i,
   input  logic [N_H-1:0]   ack_i,
   output logic [N_H-1:0]   act_o
);
   localparam int IRQ_BASE = N_ALM + N_CYC;

   generate
      if (N_ALM < 0 || N_CYC < 0 || N_IRQ < 1 || CNT_W < 2) begin : g_bad_cfg
         $error("hht_unit: slot counts or counter width out of range");
      end
   endgenerate

   logic             exec_w;
   hht_op_e          e_op;
   logic [IDX_W-1:0] e_idx;
   logic [CNT_W-1:0] e_data;
   logic [N_H-1:0]   h_active, h_pend;
   logic [CNT_W-1:0] h_count [N_H];
   logic [CNT_W-1:0] rd_count_q;
   logic             rd_active_q, rd_pend_q;

   hht_cmd_port #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_cmd (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (cmd_valid_i),
      .op_i    (cmd_op_i),
      .idx_i   (cmd_idx_i),
      .data_i  (cmd_data_i),
      .busy_o  (cmd_busy_o),
      .done_o  (cmd_done_o),
      .exec_o  (exec_w),
      .op_o    (e_op),
      .idx_o   (e_idx),
      .data_o  (e_data)
   );

   generate
      for (genvar k = 0; k < N_ALM + N_CYC; k++) begin : g_tmr
         hht_timer_slot #(.CNT_W(CNT_W), .CYCLIC(k >= N_ALM)) u_slot (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .sel_i    (exec_w && (e_idx == IDX_W'(k))),
            .op_i     (e_op),
            .data_i   (e_data),
            .ack_i    (ack_i[k]),
            .active_o (h_active[k]),
            .count_o  (h_count[k]),
            .pend_o   (h_pend[k])
         );
      end
      for (genvar j = 0; j < N_IRQ; j++) begin : g_irq
         hht_irq_slot u_slot (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .sel_i  (exec_w && (e_idx == IDX_W'(IRQ_BASE + j))),
            .op_i   (e_op),
            .ack_i  (ack_i[IRQ_BASE+j]),
            .irq_i  (irq_i[j]),
            .en_o   (h_active[IRQ_BASE+j]),
            .pend_o (h_pend[IRQ_BASE+j])
         );
         assign h_count[IRQ_BASE+j] = '0;
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rd_count_q  <= '0;
         rd_active_q <= 1'b0;
         rd_pend_q   <= 1'b0;
      end else if (exec_w && e_op == OP_REFER) begin
         if (int'(e_idx) < N_H) begin
            rd_count_q  <= h_count[e_idx];
            rd_active_q <= h_active[e_idx];
            rd_pend_q   <= h_pend[e_idx];
         end else begin
            rd_count_q  <= '0;
            rd_active_q <= 1'b0;
            rd_pend_q   <= 1'b0;
         end
      end
   end

   assign act_o       = h_pend;
   assign rd_count_o  = rd_count_q;
   assign rd_active_o = rd_active_q;
   assign rd_pend_o   = rd_pend_q;

   // R10
   bad_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (exec_w && e_op == OP_REFER && int'(e_idx) >= N_H) |=>
      (rd_count_q == '0 && !rd_active_q && !rd_pend_q));
   // R10
   rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(exec_w && e_op == OP_REFER) |=> $stable(rd_count_q));
endmodule

// File: tb/hht_unit_test.sv
`timescale 1ns/1ps
module hht_unit_test;
   localparam int NA = 2, NC = 2, NI = 2, CW = 8;
   localparam int NT = NA + NC;
   localparam int NH = NT + NI;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [1:0]    cmd_op = 2'd0;
   logic [2:0]    cmd_idx = 3'd0;
   logic [CW-1:0] cmd_data = '0;
   logic          busy, done;
   logic [CW-1:0] rd_count;
   logic          rd_active, rd_pend;
   logic [NI-1:0] irq = '0;
   logic [NH-1:0] ack = '0;
   logic [NH-1:0] act;

   int n_vec = 0, n_bad = 0;
   bit ended = 1'b0;

   always #2 clk = ~clk;

   hht_unit #(.N_ALM(NA), .N_CYC(NC), .N_IRQ(NI), .CNT_W(CW)) uut (
      .clk_i(clk), .rst_ni(rst_n),
      .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_idx_i(cmd_idx),
      .cmd_data_i(cmd_data), .cmd_busy_o(busy), .cmd_done_o(done),
      .rd_count_o(rd_count), .rd_active_o(rd_active), .rd_pend_o(rd_pend),
      .irq_i(irq), .ack_i(ack), .act_o(act)
   );

   // behavioural reference
   int m_act[NH], m_cnt[NH], m_per[NH], m_pend[NH], m_irqq[NH];
   int m_busy, m_done, m_op, m_idx, m_data, m_rdc, m_rda, m_rdp;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int h = 0; h < NH; h++) begin
            m_act[h] = 0; m_cnt[h] = 0; m_per[h] = 0; m_pend[h] = 0; m_irqq[h] = 0;
         end
         m_busy = 0; m_done = 0; m_op = 0; m_idx = 0; m_data = 0;
         m_rdc = 0; m_rda = 0; m_rdp = 0;
      end else begin
         automatic int ex = m_busy, eo = m_op, ei = m_idx, ed = m_data;
         if (ex != 0 && eo == 3) begin
            if (ei < NH) begin m_rdc = m_cnt[ei]; m_rda = m_act[ei]; m_rdp = m_pend[ei]; end
            else begin m_rdc = 0; m_rda = 0; m_rdp = 0; end
         end
         for (int h = 0; h < NH; h++) begin
            automatic bit sel = (ex != 0) && (ei == h);
            if (h < NT) begin
               automatic bit cyc = (h >= NA);
               automatic bit fire = (m_act[h] != 0) && (m_cnt[h] <= 1) &&
                                    !(sel && (eo == 0 || eo == 1));
               if (fire) m_pend[h] = 1; else if (ack[h]) m_pend[h] = 0;
               if (sel && eo == 0) begin m_act[h] = 1; m_cnt[h] = ed; end
               else if (sel && eo == 1) m_act[h] = 0;
               else if (fire) begin m_cnt[h] = cyc ? m_per[h] : 0; m_act[h] = cyc ? 1 : 0; end
               else if (m_act[h] != 0) m_cnt[h] = m_cnt[h] - 1;
               if (cyc && sel && eo == 2) m_per[h] = ed;
            end else begin
               if (m_act[h] != 0 && m_irqq[h] != 0) m_pend[h] = 1;
               else if (ack[h]) m_pend[h] = 0;
               m_irqq[h] = irq[h-NT];
               if (sel && eo == 0) m_act[h] = 1;
               else if (sel && eo == 1) m_act[h] = 0;
            end
         end
         m_done = m_busy;
         if (m_busy != 0) m_busy = 0;
         else if (cmd_valid) begin
            m_busy = 1; m_op = cmd_op; m_idx = cmd_idx; m_data = cmd_data;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int a, input int e);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, a, e, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !ended) begin
         for (int h = 0; h < NH; h++)
            chk(int'(act[h]) == m_pend[h],
                (h < NA) ? "R2 alarm request" : (h < NT) ? "R3 cyclic request" : "R4 irq request",
                int'(act[h]), m_pend[h]);
         chk(int'(busy) == m_busy, "R7 busy", int'(busy), m_busy);
         chk(int'(done) == m_done, "R7 done", int'(done), m_done);
         chk(int'(rd_count) == m_rdc, "R10 rd_count", int'(rd_count), m_rdc);
         chk(int'(rd_active) == m_rda, "R10 rd_active", int'(rd_active), m_rda);
         chk(int'(rd_pend) == m_rdp, "R10 rd_pend", int'(rd_pend), m_rdp);
      end
   end

   task automatic do_cmd(input int op, input int idx, input int data);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'(op); cmd_idx = 3'(idx); cmd_data = CW'(data);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(busy == 1'b1, "R7 busy after accept", int'(busy), 1);
      @(negedge clk);
      chk(done == 1'b1 && busy == 1'b0, "R7 done two cycles after accept", int'(done), 1);
   endtask

   task automatic pulse_ack(input int h);
      @(negedge clk); ack[h] = 1'b1;
      @(negedge clk); ack[h] = 1'b0;
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(act == '0 && !busy && !done && rd_count == '0, "R1 reset state", int'(act), 0);
      rst_n = 1'b1;

      // R2 alarm latency V=3
      do_cmd(0, 0, 3);
      @(negedge clk); chk(act[0] == 1'b0, "R2 no early fire", int'(act[0]), 0);
      @(negedge clk); chk(act[0] == 1'b0, "R2 no early fire", int'(act[0]), 0);
      @(negedge clk); chk(act[0] == 1'b1, "R2 fire on third edge", int'(act[0]), 1);
      pulse_ack(0);
      @(negedge clk); chk(act[0] == 1'b0, "R6 ack clears", int'(act[0]), 0);
      do_cmd(3, 0, 0);
      chk(rd_active == 1'b0 && rd_count == '0, "R2 alarm stopped after firing", int'(rd_active), 0);

      // R3 cyclic period 4 on slot 2, period 1 on slot 3 (R8 index layout)
      do_cmd(2, 2, 4);
      do_cmd(0, 2, 4);
      do_cmd(2, 3, 1);
      do_cmd(0, 3, 1);
      repeat (6) @(negedge clk);
      do_cmd(3, 2, 0);
      chk(rd_active == 1'b1, "R3 cyclic stays active", int'(rd_active), 1);
      // R6 held ack while slot 3 fires every cycle
      @(negedge clk); ack[3] = 1'b1;
      repeat (3) @(negedge clk);
      chk(act[3] == 1'b1, "R6 fire beats ack", int'(act[3]), 1);
      ack[3] = 1'b0;
      do_cmd(1, 3, 0);
      pulse_ack(3);
      do_cmd(1, 2, 0);
      pulse_ack(2);

      // R4 / R5 parallel interrupts
      do_cmd(0, 4, 0);
      do_cmd(0, 5, 0);
      @(negedge clk); irq = 2'b11;
      @(negedge clk); chk(act[5:4] == 2'b00, "R4 not before second edge", int'(act[5:4]), 0);
      @(negedge clk); chk(act[5:4] == 2'b11, "R5 both requests together", int'(act[5:4]), 3);
      irq = 2'b00;
      repeat (2) @(negedge clk);
      pulse_ack(4);
      @(negedge clk);
      chk(act[5:4] == 2'b10, "R6 ack only own slot", int'(act[5:4]), 2);
      pulse_ack(5);
      do_cmd(1, 4, 0);
      @(negedge clk); irq = 2'b01;
      @(negedge clk); irq = 2'b00;
      repeat (3) @(negedge clk);
      chk(act[4] == 1'b0, "R4 disabled source ignored", int'(act[4]), 0);

      // R9 restart and stop
      do_cmd(0, 1, 10);
      repeat (3) @(negedge clk);
      do_cmd(0, 1, 2);
      @(negedge clk); chk(act[1] == 1'b0, "R9 restart count", int'(act[1]), 0);
      @(negedge clk); chk(act[1] == 1'b1, "R9 restart fires at new value", int'(act[1]), 1);
      pulse_ack(1);
      do_cmd(0, 0, 5);
      @(negedge clk);
      do_cmd(1, 0, 0);
      repeat (8) @(negedge clk);
      chk(act[0] == 1'b0, "R9 stop cancels firing", int'(act[0]), 0);
      do_cmd(0, 0, 1);
      do_cmd(1, 0, 0);
      repeat (3) @(negedge clk);

      // R10 invalid index
      do_cmd(0, 7, 3);
      do_cmd(3, 6, 0);
      chk(rd_count == '0 && !rd_active && !rd_pend, "R10 invalid index reads zero",
          int'(rd_count), 0);
      repeat (4) @(negedge clk);
      chk(act == 6'b000001 || act == '0, "R10 invalid command touches nothing", int'(act), 0);
      finish_run();
   end
endmodule